// File: doc/BRIEF.md
# Serial-Loaded Four-Digit LED Multiplex Driver

This block drives a four-digit, common-anode seven-segment display with eight segment lines (seven segments plus the decimal point). A host fills an eight-stage serial-in, parallel-out register one bit at a time, using a shift-clock line and a data line. Every stage of the register drives one segment line directly, so the segment outputs always show what the register holds.

The host selects the lit digit with a separate 4-bit select code. The block registers that code and passes it through a one-of-ten decoder whose outputs are active low. Only the first four decoder outputs reach the digit anodes, so codes 0 to 3 light a digit and every other code blanks the display.

The shift-clock and data lines are sampled on the block's system clock, and a rising edge is found by comparing each sample with the one before it. A snapshot port, intended for a checker, reports the lit digit's index and the segment byte whenever exactly one anode is on.

Top module: `ledmux_serial_drv`

## Requirements
- R1: While `rst_n` is low and after it is released, `seg_o` is 8'h00, `anode_n` is 4'hF (all digits off) and `snap_valid` is 0, until the inputs change these.
- R2: If `shift_clk` is 1 at a system clock edge and was 0 at the previous edge, that edge moves every register stage up one position (stage k to stage k+1) and loads `ser_data` into stage 0. `seg_o[k]` shows stage k after that edge.
- R3: The register keeps its value at any system clock edge that does not see a 0-to-1 change on `shift_clk`. This covers `shift_clk` held high, a falling `shift_clk` and `shift_clk` held low, whatever `ser_data` does.
- R4: Bit order: after eight rising edges, the first bit sent is on `seg_o[7]` and the last bit sent is on `seg_o[0]`. A host therefore sends the segment byte most significant bit first.
- R5: `seg_o` shows the register contents whatever the select code is, including codes that turn every anode off.
- R6: One clock after `sel_code` is set to a value d from 0 to 3, `anode_n[d]` is 0 and the other three bits are 1.
- R7: One clock after `sel_code` is set to a value from 4 to 9, `anode_n` is 4'hF.
- R8: One clock after `sel_code` is set to a value from 10 to 15, `anode_n` is 4'hF.
- R9: At most one bit of `anode_n` is 0 at any time.
- R10: `snap_valid` is 1 exactly when one bit of `anode_n` is 0. While it is 1, `snap_digit` gives that bit's index and `snap_seg` equals `seg_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_clk | input | 1 | Serial shift clock from the host, synchronous to `clk` |
| ser_data | input | 1 | Serial segment data, taken on a `shift_clk` rising edge |
| sel_code | input | 4 | Digit select code fed to the one-of-ten decoder |
| seg_o | output | 8 | Segment lines, one per register stage |
| anode_n | output | 4 | Active-low digit anode enables |
| snap_valid | output | 1 | Exactly one anode is active |
| snap_digit | output | 2 | Index of the active digit |
| snap_seg | output | 8 | Segment byte shown on the active digit |

## Verification
The assertions assume that `shift_clk` and `ser_data` are already synchronous to `clk` and that each level of `shift_clk` lasts at least one system clock, so that the sampled edge is the edge the host meant. They also assume the select code is held at a system clock edge. The stimulus changes every input only on the falling edge of `clk`, and each `shift_clk` phase lasts a whole clock period. The register is loaded with the anodes both on and off, and the select code is swept across all sixteen values.

// File: rtl/ledmux_pkg.sv
package ledmux_pkg;

  localparam int SEG_W  = 8;
  localparam int NUM_DIG = 4;
  localparam int SEL_W  = 4;
  localparam int DEC_N  = 10;
  localparam int IDX_W  = $clog2(NUM_DIG);

  // One-of-ten decoder with active-low outputs; out-of-range codes give all ones.
  function automatic logic [DEC_N-1:0] dec_1of10_n(input logic [SEL_W-1:0] code);
    logic [DEC_N-1:0] r;
    r = '1;
    for (int i = 0; i < DEC_N; i++) begin
      if (code == SEL_W'(i)) r[i] = 1'b0;
    end
    return r;
  endfunction

  // Number of active (low) enables.
  function automatic int unsigned count_low(input logic [NUM_DIG-1:0] en_n);
    int unsigned n;
    n = 0;
    for (int i = 0; i < NUM_DIG; i++) begin
      if (!en_n[i]) n++;
    end
    return n;
  endfunction

  // Index of the lowest active (low) enable, zero when none.
  function automatic logic [IDX_W-1:0] low_index(input logic [NUM_DIG-1:0] en_n);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_DIG - 1; i >= 0; i--) begin
      if (!en_n[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/ledmux_shift.sv
module ledmux_shift #(
  parameter int W = ledmux_pkg::SEG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         sdata,
  output logic [W-1:0] q,
  output logic         fire
);

  logic sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= sclk;
  end

  assign fire = sclk & ~sclk_prev;

  // Stage 0 takes the serial bit; each later stage takes its neighbour below.
  for (genvar k = 0; k < W; k++) begin : g_stage
    logic nxt;
    if (k == 0) begin : g_head
      assign nxt = sdata;
    end else begin : g_body
      assign nxt = q[k-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q[k] <= 1'b0;
      else if (fire) q[k] <= nxt;
    end
  end

endmodule

// File: rtl/ledmux_digit_dec.sv
module ledmux_digit_dec #(
  parameter int SEL_W   = ledmux_pkg::SEL_W,
  parameter int NUM_DIG = ledmux_pkg::NUM_DIG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEL_W-1:0]   sel_in,
  output logic [SEL_W-1:0]   sel_q,
  output logic [NUM_DIG-1:0] anode_n
);

  logic [ledmux_pkg::DEC_N-1:0] dec_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '1;
    else        sel_q <= sel_in;
  end

  assign dec_n = ledmux_pkg::dec_1of10_n(sel_q);

  // Only the low decoder outputs reach anodes; the rest stay unconnected.
  for (genvar d = 0; d < NUM_DIG; d++) begin : g_anode
    assign anode_n[d] = dec_n[d];
  end

endmodule

// File: rtl/ledmux_snap.sv
module ledmux_snap #(
  parameter int NUM_DIG = ledmux_pkg::NUM_DIG,
  parameter int W       = ledmux_pkg::SEG_W,
  localparam int IDX_W  = ledmux_pkg::IDX_W
) (
  input  logic [NUM_DIG-1:0] anode_n,
  input  logic [W-1:0]       seg,
  output logic               valid,
  output logic [IDX_W-1:0]   idx,
  output logic [W-1:0]       seg_out
);

  assign valid   = (ledmux_pkg::count_low(anode_n) == 1);
  assign idx     = ledmux_pkg::low_index(anode_n);
  assign seg_out = seg;

endmodule

// File: rtl/ledmux_serial_drv.sv
module ledmux_serial_drv #(
  parameter int SEG_W   = ledmux_pkg::SEG_W,
  parameter int NUM_DIG = ledmux_pkg::NUM_DIG,
  parameter int SEL_W   = ledmux_pkg::SEL_W,
  localparam int IDX_W  = ledmux_pkg::IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_clk,
  input  logic               ser_data,
  input  logic [SEL_W-1:0]   sel_code,
  output logic [SEG_W-1:0]   seg_o,
  output logic [NUM_DIG-1:0] anode_n,
  output logic               snap_valid,
  output logic [IDX_W-1:0]   snap_digit,
  output logic [SEG_W-1:0]   snap_seg
);

  // Internal events brought out for the checker.
  logic             shift_fire;
  logic [SEL_W-1:0] sel_q;

  ledmux_shift #(.W(SEG_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .sclk  (shift_clk),
    .sdata (ser_data),
    .q     (seg_o),
    .fire  (shift_fire)
  );

  ledmux_digit_dec #(.SEL_W(SEL_W), .NUM_DIG(NUM_DIG)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_in  (sel_code),
    .sel_q   (sel_q),
    .anode_n (anode_n)
  );

  ledmux_snap #(.NUM_DIG(NUM_DIG), .W(SEG_W)) u_snap (
    .anode_n (anode_n),
    .seg     (seg_o),
    .valid   (snap_valid),
    .idx     (snap_digit),
    .seg_out (snap_seg)
  );

endmodule

// File: rtl/ledmux_sva.sv
module ledmux_sva #(
  parameter int SEG_W   = 8,
  parameter int NUM_DIG = 4,
  parameter int SEL_W   = 4,
  parameter int IDX_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               shift_clk,
  input logic               ser_data,
  input logic [SEL_W-1:0]   sel_code,
  input logic [SEG_W-1:0]   seg_o,
  input logic [NUM_DIG-1:0] anode_n,
  input logic               snap_valid,
  input logic [IDX_W-1:0]   snap_digit,
  input logic [SEG_W-1:0]   snap_seg,
  input logic               shift_fire
);

  assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_fire |=> seg_o == {$past(seg_o[SEG_W-2:0]), $past(ser_data)});

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_fire |=> $stable(seg_o));

  assert_fire_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_fire |-> shift_clk);

  assert_digit_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_code < SEL_W'(NUM_DIG)) |=>
      anode_n == ~({{(NUM_DIG-1){1'b0}}, 1'b1} << $past(sel_code[IDX_W-1:0])));

  assert_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_code >= SEL_W'(NUM_DIG)) |=> anode_n == '1);

  assert_one_anode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~anode_n));

  assert_snap_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    snap_valid == ($countones(~anode_n) == 1));

  assert_snap_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    snap_valid |-> (snap_seg == seg_o) && !anode_n[snap_digit]);

endmodule

bind ledmux_serial_drv ledmux_sva #(
  .SEG_W(SEG_W), .NUM_DIG(NUM_DIG), .SEL_W(SEL_W), .IDX_W(IDX_W)
) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .shift_clk  (shift_clk),
  .ser_data   (ser_data),
  .sel_code   (sel_code),
  .seg_o      (seg_o),
  .anode_n    (anode_n),
  .snap_valid (snap_valid),
  .snap_digit (snap_digit),
  .snap_seg   (snap_seg),
  .shift_fire (shift_fire)
);

// File: tb/tb_ledmux_serial_drv.sv
module tb_ledmux_serial_drv;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       shift_clk = 1'b0;
  logic       ser_data = 1'b0;
  logic [3:0] sel_code = 4'hF;
  logic [7:0] seg_o;
  logic [3:0] anode_n;
  logic       snap_valid;
  logic [1:0] snap_digit;
  logic [7:0] snap_seg;

  always #10 clk = ~clk;

  ledmux_serial_drv dut (
    .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .ser_data(ser_data),
    .sel_code(sel_code), .seg_o(seg_o), .anode_n(anode_n),
    .snap_valid(snap_valid), .snap_digit(snap_digit), .snap_seg(snap_seg)
  );

  typedef struct packed {
    logic [7:0] seg;
    logic [3:0] an;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk = 0;
  int    n_bad = 0;

  // Bench model state
  logic [7:0] m_seg = 8'h00;
  logic [3:0] m_sel = 4'hF;
  logic       m_prev = 1'b0;

  function automatic logic [3:0] exp_anode(input logic [3:0] s);
    if (s < 4) return ~(4'b0001 << s[1:0]);
    return 4'hF;
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Driver: one clock of stimulus, then push the expected result.
  task automatic apply(input string tag, input logic [3:0] sel, input logic sc, input logic sd);
    @(negedge clk);
    sel_code  = sel;
    shift_clk = sc;
    ser_data  = sd;
    @(posedge clk);
    #1;
    if (sc && !m_prev) m_seg = {m_seg[6:0], sd};
    m_prev = sc;
    m_sel  = sel;
    exp_q.push_back('{seg: m_seg, an: exp_anode(m_sel)});
    tag_q.push_back(tag);
  endtask

  // Sends a byte MSB first so it lands unchanged on seg_o (R4).
  task automatic send_byte(input logic [3:0] sel, input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      apply("R2", sel, 1'b0, b[i]);
      apply("R2", sel, 1'b1, b[i]);
    end
    apply("R4", sel, 1'b0, 1'b0);
  endtask

  // Monitor: compare popped items away from the active edge.
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      int    lows;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      lows = 0;
      for (int i = 0; i < 4; i++) if (!e.an[i]) lows++;
      check(t, "seg_o", 32'(seg_o), 32'(e.seg));
      check(t, "anode_n", 32'(anode_n), 32'(e.an));
      check("R9", "anode count<=1", 32'($countones(~anode_n) <= 1), 32'd1);
      check("R10", "snap_valid", 32'(snap_valid), 32'(lows == 1));
      if (lows == 1) begin
        check("R10", "snap_seg", 32'(snap_seg), 32'(e.seg));
        check("R10", "snap_digit lit", 32'(anode_n[snap_digit]), 32'd0);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; shift_clk = 1'b0; ser_data = 1'b0; sel_code = 4'hF;
    m_seg = 8'h00; m_sel = 4'hF; m_prev = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    check("R1", "seg_o in reset", 32'(seg_o), 32'h00);
    check("R1", "anode_n in reset", 32'(anode_n), 32'hF);
    check("R1", "snap_valid in reset", 32'(snap_valid), 32'd0);
    rst_n = 1'b1;
    apply("R1", 4'hF, 1'b0, 1'b0);
  endtask

  initial begin
    fork
      begin
        #3000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    join_none

    do_reset();
    // R5: load with every anode off
    send_byte(4'd4, 8'hA5);
    apply("R5", 4'd9, 1'b0, 1'b1);
    // R6: each digit in turn
    for (int d = 0; d < 4; d++) apply("R6", 4'(d), 1'b0, 1'b0);
    // R7: mid-range codes blank the display
    for (int c = 4; c < 10; c++) apply("R7", 4'(c), 1'b0, 1'b1);
    // R8: codes past the decoder range
    for (int c = 10; c < 16; c++) apply("R8", 4'(c), 1'b0, 1'b0);
    // R3: held high, falling, held low with toggling data
    apply("R2", 4'd1, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) apply("R3", 4'd1, 1'b1, 1'(i));
    apply("R3", 4'd1, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) apply("R3", 4'd1, 1'b0, 1'(i + 1));
    // R4: second pattern on a lit digit
    send_byte(4'd2, 8'h3C);
    send_byte(4'd3, 8'h81);
    // R2: back-to-back edges every other clock
    for (int i = 0; i < 3; i++) begin
      apply("R2", 4'd0, 1'b1, 1'b1);
      apply("R2", 4'd0, 1'b0, 1'b0);
    end
    do_reset();
    apply("R1", 4'hF, 1'b0, 1'b0);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule